// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block watches a live calendar (year, month, day of month, weekday, hour, minute, second) supplied by a separate time-keeping counter. It compares that calendar against a programmed alarm and raises an interrupt when every selected field agrees. Each of the seven fields has its own select bit. A master arm bit must be set before any comparison can succeed.

Software programs the block through a small word-wide write port with four addresses: date alarm, time alarm, interrupt enable and interrupt force. The `armed` output follows the master arm bit one cycle later. `raw_irq` is the registered result of the comparison. `irq` is the final line after masking and forcing. The live fields keep the same widths and encodings as the alarm fields. Advancing the calendar is not part of this block.

Top module: `cal_alarm`

## Requirements
- R1: After reset `armed`, `raw_irq` and `irq` are all 0, and all alarm values, selects, the arm bit, the enable and the force are 0.
- R2: `armed` equals the master arm bit as it stood one clock earlier.
- R3: When `armed` is 1 and every selected live field equals its alarm value, `raw_irq` is 1 from the following clock edge.
- R4: A field whose select bit is 0 has no effect on `raw_irq`, whatever its live value.
- R5: With `armed` at 1 and no field selected, `raw_irq` is 1 on every cycle after the next edge.
- R6: `raw_irq` goes to 0 one edge after a selected field stops matching, or one edge after `armed` goes to 0.
- R7: `irq` equals (`raw_irq` AND enable) OR force, combinationally.
- R8: While the force bit is 1, `irq` is 1 whatever the match and enable state.
- R9: Write layout: address 0 holds year [11:0], month [15:12], day [20:16], year/month/day selects [24]/[25]/[26] and the master arm [31]. Address 1 holds second [5:0], minute [11:6], hour [16:12], weekday [19:17] and second/minute/hour/weekday selects [24]/[25]/[26]/[27]. Address 2 bit 0 is the interrupt enable. Address 3 bit 0 is the force. A write takes effect at the clock edge where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| live_year | input | 12 | Live year |
| live_month | input | 4 | Live month |
| live_day | input | 5 | Live day of month |
| live_wday | input | 3 | Live weekday |
| live_hour | input | 5 | Live hour |
| live_min | input | 6 | Live minute |
| live_sec | input | 6 | Live second |
| armed | output | 1 | Alarm comparison armed |
| raw_irq | output | 1 | Unmasked match status |
| irq | output | 1 | Final interrupt line |

## Verification
A select bit stored against the wrong field, or an alarm value in the wrong bit positions, shows up as a wrong `raw_irq` one edge after the matching live value appears. The bench therefore keeps the live fields and the alarm values inside small value sets, so that full matches and single-field mismatches both happen often. A stale arm bit shows up on `armed` after one edge and on `raw_irq` after two. Mask and force errors reach `irq` in the same cycle that the enable, force or `raw_irq` changes.

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [YW-1:0] live_year,
  input  logic [3:0]    live_month,
  input  logic [4:0]    live_day,
  input  logic [2:0]    live_wday,
  input  logic [4:0]    live_hour,
  input  logic [5:0]    live_min,
  input  logic [5:0]    live_sec,
  output logic          armed,
  output logic          raw_irq,
  output logic          irq
);
  logic [YW-1:0] a_year;
  logic [3:0]    a_month;
  logic [4:0]    a_day, a_hour;
  logic [2:0]    a_wday;
  logic [5:0]    a_min, a_sec;
  logic [6:0]    sel;
  logic          gen_q, ie_q, force_q, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_year <= '0; a_month <= '0; a_day <= '0; a_wday <= '0;
      a_hour <= '0; a_min <= '0; a_sec <= '0; sel <= '0;
      gen_q <= 1'b0; ie_q <= 1'b0; force_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          a_year  <= wr_data[YW-1:0];
          a_month <= wr_data[15:12];
          a_day   <= wr_data[20:16];
          sel[2:0] <= wr_data[26:24];
          gen_q   <= wr_data[31];
        end
        2'd1: begin
          a_sec  <= wr_data[5:0];
          a_min  <= wr_data[11:6];
          a_hour <= wr_data[16:12];
          a_wday <= wr_data[19:17];
          sel[6:3] <= wr_data[27:24];
        end
        2'd2: ie_q <= wr_data[0];
        default: force_q <= wr_data[0];
      endcase
    end
  end

  assign hit = (!sel[0] || live_year  == a_year)
            && (!sel[1] || live_month == a_month)
            && (!sel[2] || live_day   == a_day)
            && (!sel[3] || live_sec   == a_sec)
            && (!sel[4] || live_min   == a_min)
            && (!sel[5] || live_hour  == a_hour)
            && (!sel[6] || live_wday  == a_wday);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      raw_irq <= 1'b0;
    end else begin
      armed   <= gen_q;
      raw_irq <= armed && hit;
    end
  end

  assign irq = (raw_irq && ie_q) || force_q;

  p_armed_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (armed == $past(gen_q)));
  p_raw_needs_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raw_irq |-> $past(armed));
  p_disarm_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !raw_irq);
  p_force_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> irq);
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_q && !ie_q) |-> !irq);
endmodule

// File: tb/tb_cal_alarm.sv
module tb_cal_alarm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] live_year = '0;
  logic [3:0] live_month = '0;
  logic [4:0] live_day = '0, live_hour = '0;
  logic [2:0] live_wday = '0;
  logic [5:0] live_min = '0, live_sec = '0;
  logic armed, raw_irq, irq;

  int vectors = 0, errors = 0;
  logic [31:0] m_date = '0, m_time = '0;
  logic m_ie = 0, m_force = 0, m_armed = 0, m_raw = 0;

  always #4 clk = ~clk;

  cal_alarm dut (.*);

  function automatic logic fmatch(input logic [31:0] d, input logic [31:0] t);
    return (!d[24] || live_year  == d[11:0])
        && (!d[25] || live_month == d[15:12])
        && (!d[26] || live_day   == d[20:16])
        && (!t[24] || live_sec   == t[5:0])
        && (!t[25] || live_min   == t[11:6])
        && (!t[26] || live_hour  == t[16:12])
        && (!t[27] || live_wday  == t[19:17]);
  endfunction

  task automatic chk(input string tag);
    logic exp_irq;
    exp_irq = (m_raw & m_ie) | m_force;
    vectors++;
    if (armed !== m_armed || raw_irq !== m_raw || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s armed/raw/irq=%b%b%b expected %b%b%b", tag,
               armed, raw_irq, irq, m_armed, m_raw, exp_irq);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input string tag);
    logic n_armed, n_raw;
    wr_en = we; wr_addr = a; wr_data = d;
    n_armed = m_date[31];
    n_raw = m_armed & fmatch(m_date, m_time);
    if (we) case (a)
      2'd0: m_date = d;
      2'd1: m_time = d;
      2'd2: m_ie = d[0];
      default: m_force = d[0];
    endcase
    @(posedge clk);
    m_armed = n_armed; m_raw = n_raw;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag);
  endtask

  task automatic set_live(input logic [11:0] y, input logic [3:0] mo, input logic [4:0] dd,
                          input logic [2:0] w, input logic [4:0] h, input logic [5:0] mi,
                          input logic [5:0] s);
    live_year = y; live_month = mo; live_day = dd; live_wday = w;
    live_hour = h; live_min = mi; live_sec = s;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release");
    // R2/R5: arm with no field selected
    set_live(12'd2025, 4'd3, 5'd7, 3'd2, 5'd10, 6'd30, 6'd15);
    step(1, 2'd0, 32'h8000_0000, "R2 arm write");
    step(0, 2'd0, 0, "R2 armed one later");
    step(0, 2'd0, 0, "R5 no select matches");
    step(1, 2'd2, 32'h1, "R7 enable on");
    step(0, 2'd0, 0, "R7 irq follows raw");
    // R3/R4: select seconds only, mismatch other fields
    step(1, 2'd1, 32'h0100_0000 | 32'd20, "R4 sec select");
    step(0, 2'd0, 0, "R6 mismatch clears");
    live_sec = 6'd20; live_min = 6'd59;
    step(0, 2'd0, 0, "R3 sec match");
    step(0, 2'd0, 0, "R4 unselected min ignored");
    live_sec = 6'd21;
    step(0, 2'd0, 0, "R6 drop on mismatch");
    live_sec = 6'd20;
    step(0, 2'd0, 0, "R3 rematch");
    step(1, 2'd2, 32'h0, "R7 masked");
    step(1, 2'd3, 32'h1, "R8 force on");
    step(1, 2'd0, 32'h0, "R6 disarm");
    step(0, 2'd0, 0, "R6 disarm armed low");
    step(0, 2'd0, 0, "R8 force without raw");
    step(1, 2'd3, 32'h0, "R8 force off");
    // random phase, small value sets for frequent matches (R9 layout)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [1:0] a;
      logic we;
      set_live(12'($urandom_range(1)), 4'($urandom_range(1)), 5'($urandom_range(1)),
               3'($urandom_range(1)), 5'($urandom_range(1)), 6'($urandom_range(1)),
               6'($urandom_range(1)));
      we = ($urandom_range(3) == 0);
      a = 2'($urandom_range(3));
      d = '0;
      case (a)
        2'd0: d = {$urandom_range(3) != 0 ? 1'b1 : 1'b0, 4'd0, 3'($urandom),
                   3'd0, 5'($urandom_range(1)), 4'($urandom_range(1)), 12'($urandom_range(1))};
        2'd1: d = {4'd0, 4'($urandom), 4'd0, 3'($urandom_range(1)), 5'($urandom_range(1)),
                   6'($urandom_range(1)), 6'($urandom_range(1))};
        2'd2: d = {31'd0, 1'($urandom)};
        default: d = {31'd0, ($urandom_range(7) == 0) ? 1'b1 : 1'b0};
      endcase
      step(we, a, d, "R9 random R3 R4 R6 R7");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule